// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the bus-facing core of an I2C master. Software hands it one command word, which may ask for several bus operations together. The possible operations are a start condition with an address byte, a data byte sent out, a data byte read in, and a stop condition. The block runs the requested operations one at a time in a fixed order. It drops each command bit once that step is done, and it reports each outcome in a small set of status flags. Once the whole word has been handled, a single interrupt line reports the result through a per-flag enable mask.

A shared byte engine drives the two open-drain lines, SCL and SDA. It generates start and stop conditions and shifts bytes in and out. It also handles the ninth, acknowledge bit. A quarter-bit timer paces each bit, and a programmable divider sets the timer's rate. The address or data byte to send comes from the `tx_byte` input. The last byte received is held on `rx_byte`.

Top module: `i2cm_cmd_seq`

## Requirements
- R1: When several operation bits are set in one command word, the block runs them in this order: start, then transmit, then receive, then stop. The command bit positions are: bit 0 start, bit 1 transmit, bit 2 receive, bit 3 last-receive, bit 4 stop.
- R2: A start operation generates a start condition and then sends `tx_byte` as the address. Completing that byte retires both the start bit and the transmit bit, so the byte is not sent a second time.
- R3: A NAK on any transmitted byte, address or data, cancels every operation still pending from that word. The block then releases the bus with a stop condition and does not set the normal-stop flag.
- R4: An acknowledged transmit byte sets the tx-ack flag (status bit 0). A NAK instead sets both the tx-nak flag (bit 1) and the abnormal flag (bit 4).
- R5: A finished receive byte sets the rx-done flag (bit 2) and places the byte, MSB first off the bus, on `rx_byte`.
- R6: A requested stop operation sets the normal-stop flag (bit 3) and leaves both lines released. Between command words that contain no stop, the block keeps SCL held low.
- R7: Each accepted command word first clears all status flags and all leftover command bits.
- R8: `irq` stays low while a command word is being processed. It is evaluated only after the last step of that word.
- R9: After a command word completes, `irq` is the OR over all five flags of the flag ANDed with its bit in `int_en`.
- R10: A receive with the last-receive bit answers the byte with NAK. A receive without it answers with ACK.
- R11: `busy` rises on an accepted command strobe and stays high until every requested operation has retired. A strobe that arrives while `busy` is high has no effect on the bus or on the flags.
- R12: Each bit on the bus lasts 4*(`clk_div`+1) clock cycles.
- R13: After reset, `busy`, `status` and `irq` are 0, and neither line is driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | Quarter-bit divider; one quarter lasts clk_div+1 cycles |
| cmd_valid | input | 1 | Strobe that presents a command word |
| cmd_bits | input | 5 | Command word: start, transmit, receive, last-receive, stop |
| tx_byte | input | 8 | Address or data byte to send |
| int_en | input | 5 | Per-flag interrupt enable |
| busy | output | 1 | Command word in progress |
| status | output | 5 | tx-ack, tx-nak, rx-done, normal-stop, abnormal |
| irq | output | 1 | Masked OR of the status flags |
| rx_byte | output | 8 | Last byte received |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The hardest cases to reach are early terminations: a NAK on the address or on a data byte while receive and stop bits are still pending. Only a bus partner that refuses to acknowledge can produce them. The bench therefore models the addressed device on the bus with separate switches for acknowledging the address and acknowledging data. It then checks that the aborting stop appears with no receive byte before it. A second hard case is a strobe that arrives in the middle of a sequence. The bench fires one while a transfer is in progress and confirms that no extra bus event or flag follows.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int CMD_W  = 5;
    localparam int FLAG_W = 5;

    // command word, bit 0 = start ... bit 4 = stop
    typedef struct packed {
        logic stop;
        logic rx_last;
        logic rx;
        logic tx;
        logic start;
    } cmd_t;

    // status flags, bit 0 = tx_ack ... bit 4 = abnormal
    typedef struct packed {
        logic abnormal;
        logic nstop;
        logic rx_done;
        logic tx_nak;
        logic tx_ack;
    } flags_t;

    typedef enum logic [1:0] {OP_ADDR, OP_TX, OP_RX, OP_STOP} op_e;
    typedef enum logic [1:0] {BE_IDLE, BE_START, BE_BITS, BE_STOP} be_st_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_PICK, SQ_WAIT} sq_st_e;

    function automatic logic any_action(input cmd_t c);
        return c.start | c.tx | c.rx | c.stop;
    endfunction

endpackage

// File: rtl/i2cm_qtimer.sv
module i2cm_qtimer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div);
endmodule

// File: rtl/i2cm_byte_engine.sv
module i2cm_byte_engine
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              go,
    input  op_e               op,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              send_nak,
    input  logic              sda_in,
    output logic              run,
    output logic              done,
    output logic              nak,
    output logic [BYTE_W-1:0] rx_data,
    output logic              scl_low,
    output logic              sda_low
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

    be_st_e            st;
    logic [1:0]        ph;
    logic [CNT_W-1:0]  bitn;
    logic [BYTE_W-1:0] sh;
    logic              own;
    logic              is_rx;
    logic              nak_out;
    logic              scl_d, sda_d;

    assign run     = (st != BE_IDLE);
    assign rx_data = sh;

    // line levels for the current quarter
    always_comb begin
        scl_d = own;
        sda_d = 1'b0;
        unique case (st)
            BE_IDLE:  begin scl_d = own;                        sda_d = 1'b0;       end
            BE_START: begin scl_d = (ph == 2'd0) || (ph == 2'd3); sda_d = ph[1];      end
            BE_BITS:  begin
                scl_d = ~ph[1];
                if (bitn == ACK_SLOT) sda_d = is_rx & ~nak_out;
                else                  sda_d = ~is_rx & ~sh[BYTE_W-1];
            end
            BE_STOP:  begin scl_d = (ph == 2'd0);               sda_d = ~ph[1];     end
            default:  begin scl_d = own;                        sda_d = 1'b0;       end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= BE_IDLE;
            ph      <= '0;
            bitn    <= '0;
            sh      <= '0;
            own     <= 1'b0;
            is_rx   <= 1'b0;
            nak_out <= 1'b0;
            nak     <= 1'b0;
            done    <= 1'b0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            done    <= 1'b0;
            scl_low <= scl_d;
            sda_low <= sda_d;
            unique case (st)
                BE_IDLE: if (go) begin
                    ph   <= '0;
                    bitn <= '0;
                    unique case (op)
                        OP_ADDR: begin st <= BE_START; sh <= tx_data; is_rx <= 1'b0; end
                        OP_TX:   begin st <= BE_BITS;  sh <= tx_data; is_rx <= 1'b0; end
                        OP_RX:   begin st <= BE_BITS;  sh <= '0; is_rx <= 1'b1; nak_out <= send_nak; end
                        OP_STOP: begin st <= BE_STOP; end
                        default: st <= BE_IDLE;
                    endcase
                end
                BE_START: if (tick) begin
                    ph <= ph + 2'd1;
                    if (ph == 2'd3) begin
                        st  <= BE_BITS;
                        own <= 1'b1;
                    end
                end
                BE_BITS: if (tick) begin
                    ph <= ph + 2'd1;
                    if (ph == 2'd2) begin
                        if (bitn == ACK_SLOT) nak <= sda_in;
                        else if (is_rx)       sh  <= {sh[BYTE_W-2:0], sda_in};
                    end
                    if (ph == 2'd3) begin
                        if (bitn == ACK_SLOT) begin
                            st   <= BE_IDLE;
                            done <= 1'b1;
                        end else begin
                            bitn <= bitn + 1'b1;
                            if (!is_rx) sh <= {sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                BE_STOP: if (tick) begin
                    ph <= ph + 2'd1;
                    if (ph == 2'd3) begin
                        st   <= BE_IDLE;
                        own  <= 1'b0;
                        done <= 1'b1;
                    end
                end
                default: st <= BE_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_seq_ctrl.sv
module i2cm_seq_ctrl
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  cmd_t              cmd_in,
    input  logic              be_done,
    input  logic              be_nak,
    input  logic [BYTE_W-1:0] be_rx,
    output logic              go,
    output op_e               op_q,
    output logic              send_nak,
    output logic              busy,
    output flags_t            flags,
    output logic              irq_arm,
    output logic [BYTE_W-1:0] rx_byte
);
    sq_st_e st;
    cmd_t   pend;
    logic   abort_stop;
    logic   need_abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            pend       <= '0;
            op_q       <= OP_STOP;
            go         <= 1'b0;
            send_nak   <= 1'b0;
            busy       <= 1'b0;
            flags      <= '0;
            irq_arm    <= 1'b0;
            rx_byte    <= '0;
            abort_stop <= 1'b0;
            need_abort <= 1'b0;
        end else begin
            go <= 1'b0;
            unique case (st)
                SQ_IDLE: if (cmd_valid) begin
                    pend       <= cmd_in;
                    flags      <= '0;
                    irq_arm    <= 1'b0;
                    busy       <= 1'b1;
                    need_abort <= 1'b0;
                    st         <= SQ_PICK;
                end
                SQ_PICK: begin
                    abort_stop <= 1'b0;
                    if (need_abort || any_action(pend)) begin
                        go <= 1'b1;
                        st <= SQ_WAIT;
                    end
                    if (need_abort) begin
                        op_q       <= OP_STOP;
                        abort_stop <= 1'b1;
                        need_abort <= 1'b0;
                    end else if (pend.start) begin
                        op_q <= OP_ADDR;
                    end else if (pend.tx) begin
                        op_q <= OP_TX;
                    end else if (pend.rx) begin
                        op_q     <= OP_RX;
                        send_nak <= pend.rx_last;
                    end else if (pend.stop) begin
                        op_q <= OP_STOP;
                    end else begin
                        st      <= SQ_IDLE;
                        busy    <= 1'b0;
                        irq_arm <= 1'b1;
                        pend    <= '0;
                    end
                end
                SQ_WAIT: if (be_done) begin
                    st <= SQ_PICK;
                    unique case (op_q)
                        OP_ADDR, OP_TX: begin
                            pend.tx <= 1'b0;
                            if (op_q == OP_ADDR) pend.start <= 1'b0;
                            if (be_nak) begin
                                flags.tx_nak   <= 1'b1;
                                flags.abnormal <= 1'b1;
                                pend           <= '0;
                                need_abort     <= 1'b1;
                            end else begin
                                flags.tx_ack <= 1'b1;
                            end
                        end
                        OP_RX: begin
                            pend.rx       <= 1'b0;
                            pend.rx_last  <= 1'b0;
                            flags.rx_done <= 1'b1;
                            rx_byte       <= be_rx;
                        end
                        OP_STOP: begin
                            pend.stop <= 1'b0;
                            if (!abort_stop) flags.nstop <= 1'b1;
                        end
                        default: st <= SQ_PICK;
                    endcase
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_cmd_seq.sv
module i2cm_cmd_seq
    import i2cm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_bits,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [FLAG_W-1:0] int_en,
    output logic              busy,
    output logic [FLAG_W-1:0] status,
    output logic              irq,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              sda_in
);
    logic              tick, be_run, be_go, be_done, be_nak, send_nak, irq_arm;
    logic [BYTE_W-1:0] be_rx;
    op_e               op;
    flags_t            flags;

    i2cm_qtimer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst(rst), .run(be_run), .div(clk_div), .tick(tick)
    );

    i2cm_byte_engine u_engine (
        .clk(clk), .rst(rst), .tick(tick), .go(be_go), .op(op),
        .tx_data(tx_byte), .send_nak(send_nak), .sda_in(sda_in),
        .run(be_run), .done(be_done), .nak(be_nak), .rx_data(be_rx),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low)
    );

    i2cm_seq_ctrl u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_in(cmd_t'(cmd_bits)),
        .be_done(be_done), .be_nak(be_nak), .be_rx(be_rx),
        .go(be_go), .op_q(op), .send_nak(send_nak), .busy(busy),
        .flags(flags), .irq_arm(irq_arm), .rx_byte(rx_byte)
    );

    assign status = flags;
    assign irq    = irq_arm & (|(flags & int_en));
endmodule

// File: rtl/i2cm_seq_checker.sv
module i2cm_seq_checker
    import i2cm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              irq,
    input logic [FLAG_W-1:0] status
);
    AST_IRQ_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !irq); // R8

    AST_FLAGS_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (status == '0)); // R7

    AST_FLAGS_STABLE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(status)); // R11

    AST_NAK_MARKS_ABNORMAL: assert property (@(posedge clk) disable iff (rst)
        status[1] |-> status[4]); // R4

    AST_ACK_NAK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(status[0] && status[1])); // R4

    AST_NO_NORMAL_STOP_AFTER_NAK: assert property (@(posedge clk) disable iff (rst)
        status[1] |-> !status[3]); // R3
endmodule

bind i2cm_cmd_seq i2cm_seq_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .irq(irq), .status(status)
);

// File: tb/tb_i2cm_cmd_seq.sv
module tb_i2cm_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 100000;
    localparam logic [4:0] C_START = 5'h01, C_TX = 5'h02, C_RX = 5'h04,
                           C_LAST = 5'h08, C_STOP = 5'h10;
    localparam logic [1:0] EV_START = 2'd1, EV_BYTE = 2'd2, EV_STOP = 2'd3;

    logic        clk = 1'b0, rst = 1'b1;
    logic [15:0] clk_div = 16'd2;
    logic        cmd_valid = 1'b0;
    logic [4:0]  cmd_bits = '0;
    logic [7:0]  tx_byte = '0;
    logic [4:0]  int_en = 5'h1f;
    logic        busy, irq, scl_drive_low, sda_drive_low;
    logic [4:0]  status;
    logic [7:0]  rx_byte;
    logic        slv_low = 1'b0;

    wire scl_line = ~scl_drive_low;
    wire sda_line = ~(sda_drive_low | slv_low);

    i2cm_cmd_seq dut (
        .clk(clk), .rst(rst), .clk_div(clk_div), .cmd_valid(cmd_valid),
        .cmd_bits(cmd_bits), .tx_byte(tx_byte), .int_en(int_en), .busy(busy),
        .status(status), .irq(irq), .rx_byte(rx_byte),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_in(sda_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0, checks = 0, fails = 0, irq_busy_bad = 0;
    always @(posedge clk) cyc++;

    logic [10:0] exp_q[$];
    string       exp_tag[$];

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [1:0] k, input logic [7:0] d,
                             input logic a, input string tag);
        exp_q.push_back({k, d, a});
        exp_tag.push_back(tag);
    endtask

    // monitor side of the scoreboard
    task automatic observe(input logic [10:0] ev);
        logic [10:0] e;
        string       t;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R11 unexpected bus event actual=%0h expected=none", ev);
        end else begin
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            if (e !== ev) begin
                fails++;
                $display("FAIL %s bus event actual=%0h expected=%0h", t, ev, e);
            end
        end
    endtask

    // bus sniffer and modelled target device
    int         bitn = -1, last_rise = 0, last_gap = 0;
    bit         active = 0, first = 0, reading = 0, ack_seen = 0;
    bit         ack_addr = 1, ack_data = 1;
    bit         scl_p = 1, sda_p = 1;
    logic [7:0] sh = '0, slv_rd = '0;

    always @(negedge clk) begin
        if (rst) begin
            active = 0; reading = 0; bitn = -1; scl_p = 1; sda_p = 1; slv_low = 1'b0;
        end else begin
            if (scl_line && scl_p && sda_p && !sda_line) begin
                observe({EV_START, 8'h00, 1'b0});
                active = 1; first = 1; reading = 0; bitn = -1;
            end else if (scl_line && scl_p && !sda_p && sda_line) begin
                observe({EV_STOP, 8'h00, 1'b0});
                active = 0; reading = 0;
            end else if (active && scl_line && !scl_p) begin
                if (bitn >= 0 && bitn < 8) begin
                    sh = {sh[6:0], sda_line};
                    if (bitn > 0) last_gap = cyc - last_rise;
                    last_rise = cyc;
                end else if (bitn == 8) begin
                    ack_seen = sda_line;
                    observe({EV_BYTE, sh, sda_line});
                end
            end else if (active && !scl_line && scl_p) begin
                if (bitn == 8) begin
                    bitn = 0;
                    if (first) reading = sh[0] & ~ack_seen;
                    else if (reading && ack_seen) reading = 0;
                    first = 0;
                end else begin
                    bitn++;
                end
            end
            scl_p = scl_line;
            sda_p = sda_line;
            slv_low = active && ((bitn == 8 && !reading && (first ? ack_addr : ack_data)) ||
                                 (bitn >= 0 && bitn < 8 && reading && !slv_rd[7-bitn]));
        end
    end

    // driver
    task automatic do_cmd(input logic [4:0] c, input logic [7:0] t);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_bits = c; tx_byte = t;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) begin
            if (irq) irq_busy_bad++;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WDOG);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R13 reset state
        check_eq("R13", "busy", busy, 0);
        check_eq("R13", "status", status, 0);
        check_eq("R13", "irq", irq, 0);
        check_eq("R13", "scl", scl_drive_low, 0);
        check_eq("R13", "sda", sda_drive_low, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R6 R12: start+stop, address acked
        expect_ev(EV_START, 8'h00, 1'b0, "R6");
        expect_ev(EV_BYTE, 8'hA0, 1'b0, "R2");
        expect_ev(EV_STOP, 8'h00, 1'b0, "R6");
        int_en = 5'b01000;
        do_cmd(C_START | C_STOP, 8'hA0);
        check_eq("R6", "status", status, 5'b01001);
        check_eq("R9", "irq", irq, 1);
        check_eq("R12", "bit period div2", last_gap, 12);
        check_eq("R6", "scl released", scl_drive_low, 0);

        // R2: start+tx sends the address once
        expect_ev(EV_START, 8'h00, 1'b0, "R2");
        expect_ev(EV_BYTE, 8'hA0, 1'b0, "R2");
        expect_ev(EV_STOP, 8'h00, 1'b0, "R2");
        do_cmd(C_START | C_TX | C_STOP, 8'hA0);
        check_eq("R2", "status", status, 5'b01001);

        // separate words: start, tx, rx, stop
        expect_ev(EV_START, 8'h00, 1'b0, "R1");
        expect_ev(EV_BYTE, 8'hA0, 1'b0, "R4");
        do_cmd(C_START, 8'hA0);
        check_eq("R4", "status after addr", status, 5'b00001);
        check_eq("R6", "scl held", scl_drive_low, 1);
        expect_ev(EV_BYTE, 8'h5C, 1'b0, "R4");
        do_cmd(C_TX, 8'h5C);
        check_eq("R4", "status after data", status, 5'b00001);
        expect_ev(EV_BYTE, 8'hFF, 1'b0, "R10");
        do_cmd(C_RX, 8'h00);
        check_eq("R7", "status after rx", status, 5'b00100);
        check_eq("R5", "rx_byte", rx_byte, 8'hFF);
        expect_ev(EV_STOP, 8'h00, 1'b0, "R6");
        do_cmd(C_STOP, 8'h00);
        check_eq("R6", "status after stop", status, 5'b01000);
        check_eq("R6", "sda released", sda_drive_low, 0);

        // R1 R10: read with last-receive
        slv_rd = 8'h3C;
        expect_ev(EV_START, 8'h00, 1'b0, "R1");
        expect_ev(EV_BYTE, 8'hA1, 1'b0, "R1");
        expect_ev(EV_BYTE, 8'h3C, 1'b1, "R10");
        expect_ev(EV_STOP, 8'h00, 1'b0, "R1");
        do_cmd(C_START | C_RX | C_LAST | C_STOP, 8'hA1);
        check_eq("R5", "status", status, 5'b01101);
        check_eq("R5", "rx_byte", rx_byte, 8'h3C);

        // R1: all four bits set, receive answered with ack
        slv_rd = 8'h96;
        expect_ev(EV_START, 8'h00, 1'b0, "R1");
        expect_ev(EV_BYTE, 8'hA1, 1'b0, "R1");
        expect_ev(EV_BYTE, 8'h96, 1'b0, "R10");
        expect_ev(EV_STOP, 8'h00, 1'b0, "R1");
        do_cmd(C_START | C_TX | C_RX | C_STOP, 8'hA1);
        check_eq("R1", "status", status, 5'b01101);
        check_eq("R5", "rx_byte", rx_byte, 8'h96);

        // R3: address NAK skips receive and stop
        ack_addr = 0;
        expect_ev(EV_START, 8'h00, 1'b0, "R3");
        expect_ev(EV_BYTE, 8'hB1, 1'b1, "R3");
        expect_ev(EV_STOP, 8'h00, 1'b0, "R3");
        do_cmd(C_START | C_RX | C_LAST | C_STOP, 8'hB1);
        check_eq("R3", "status", status, 5'b10010);
        check_eq("R3", "rx_byte kept", rx_byte, 8'h96);
        check_eq("R3", "scl released", scl_drive_low, 0);
        ack_addr = 1;

        // R3 R4: data NAK
        expect_ev(EV_START, 8'h00, 1'b0, "R4");
        expect_ev(EV_BYTE, 8'hA0, 1'b0, "R4");
        do_cmd(C_START, 8'hA0);
        ack_data = 0;
        expect_ev(EV_BYTE, 8'h77, 1'b1, "R4");
        expect_ev(EV_STOP, 8'h00, 1'b0, "R3");
        do_cmd(C_TX | C_RX | C_STOP, 8'h77);
        check_eq("R4", "status", status, 5'b10010);
        ack_data = 1;

        // R11: strobe while busy is ignored
        expect_ev(EV_START, 8'h00, 1'b0, "R11");
        expect_ev(EV_BYTE, 8'hA0, 1'b0, "R11");
        expect_ev(EV_STOP, 8'h00, 1'b0, "R11");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_bits = C_START | C_STOP; tx_byte = 8'hA0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check_eq("R11", "busy after strobe", busy, 1);
        repeat (30) @(negedge clk);
        cmd_valid = 1'b1; cmd_bits = C_RX | C_STOP;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) begin
            if (irq) irq_busy_bad++;
            @(negedge clk);
        end
        repeat (200) @(negedge clk);
        check_eq("R11", "status", status, 5'b01001);
        check_eq("R11", "events pending", exp_q.size(), 0);

        // R9: mask selects flags
        int_en = 5'b00100;
        @(negedge clk);
        check_eq("R9", "irq masked", irq, 0);
        int_en = 5'b00001;
        @(negedge clk);
        check_eq("R9", "irq tx_ack", irq, 1);

        // R12: slower divider
        clk_div = 16'd5;
        expect_ev(EV_START, 8'h00, 1'b0, "R12");
        expect_ev(EV_BYTE, 8'hA0, 1'b0, "R12");
        expect_ev(EV_STOP, 8'h00, 1'b0, "R12");
        do_cmd(C_START | C_STOP, 8'hA0);
        check_eq("R12", "bit period div5", last_gap, 24);

        check_eq("R8", "irq high while busy", irq_busy_bad, 0);
        check_eq("R1", "events pending at end", exp_q.size(), 0);
        summary();
    end
endmodule